// File: doc/BRIEF.md
# Indexed RTC Register File with Interrupt Flags

This block is the host side of a real-time clock. The host reaches 128 bytes of byte storage through two ports. A write to the even port selects an index. An access to the odd port then reads or writes the byte at that index. Four of the indices hold control and status registers rather than plain storage:

| Index | Register | Role |
|-------|----------|------|
| 0x0A | A | Divider and rate control, plus a read-only update-busy bit |
| 0x0B | B | Mode bits and interrupt enables |
| 0x0C | C | Interrupt flags |
| 0x0D | D | Fixed status |

The timekeeping logic sits outside this block. It sends one-cycle pulses for update-ended, alarm and periodic events, and a level that shows an update is in progress. The block latches each event as a flag in register C. It drives one interrupt line when a newly latched flag has its enable set. The host clears all flags by reading register C.

The fields the timekeeping logic needs go back out on dedicated control outputs: rate select, divider select, set mode, square-wave enable, binary mode, 24-hour mode and daylight-saving enable. Read data is registered. It appears one cycle after the read strobe.

Top module: `rtcif_regfile`

## Requirements
- R1: A write to the even port (`bus_addr0`=0) loads the index from data bits [6:0], so bit 7 is dropped. A read of the even port returns 0xFF.
- R2: A write to the odd port (`bus_addr0`=1) stores the byte at the current index. A read of the odd port returns the byte at the current index on `rd_data` one cycle after the strobe. This applies to every index other than 0x0A to 0x0D.
- R3: Writes to index 0x0C (flags) and index 0x0D (status) have no effect. Index 0x0D always reads 0x80.
- R4: Bit 7 of register A (index 0x0A) reads as the registered `tk_busy` level while SET is 0, and reads 0 while SET is 1. A write cannot change bit 7. Bits [6:0] are written normally.
- R5: A read of register C returns its current value. On the same edge the block clears the register to 0x00 and lowers `irq`.
- R6: The register C flags are PF=bit 6, AF=bit 5 and UF=bit 4. They are set by `tk_periodic`, `tk_alarm` and `tk_update` respectively. The enables in register B sit at the same bit positions (PIE=6, AIE=5, UIE=4). When a newly set flag has its enable set, IRQF (bit 7 of C) and `irq` rise on that edge. A flag whose enable is clear is still latched, but it raises nothing.
- R7: A write to register B raises IRQF and `irq` at once if any flag already pending in C is enabled by the new value. Otherwise the write clears IRQF and lowers `irq`.
- R8: A write to register B with bit 7 (SET) at 1 stores bit 4 (UIE) as 0.
- R9: Reset gives A=0x26, B=0x02, C=0x00 and D=0x80, with `irq` low.
- R10: An event pulse in the same cycle as a read of register C is not lost. The read returns the old value, and the new flag (with IRQF and `irq` if enabled) is present afterwards.
- R11: The control outputs follow the registers: `ctl_rate`=A[3:0], `ctl_divsel`=A[6:4], `ctl_set`=B[7], `ctl_sqw_en`=B[3], `ctl_binary`=B[2], `ctl_24h`=B[1], `ctl_dst`=B[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr0 | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle; takes priority over `bus_rd` |
| tk_update | input | 1 | Update-ended event pulse |
| tk_alarm | input | 1 | Alarm event pulse |
| tk_periodic | input | 1 | Periodic event pulse |
| tk_busy | input | 1 | Update-in-progress level from the timekeeper |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |
| ctl_rate | output | 4 | Periodic rate select |
| ctl_divsel | output | 3 | Divider select |
| ctl_set | output | 1 | Set mode (time updates halted) |
| ctl_sqw_en | output | 1 | Square-wave enable |
| ctl_binary | output | 1 | Binary rather than BCD data mode |
| ctl_24h | output | 1 | 24-hour mode |
| ctl_dst | output | 1 | Daylight-saving enable |

## Verification
The hardest cases to reach from the ports are where an event and a host action land on the same edge. Two such cases matter:

- An event pulse arrives exactly as register C is read.
- A register B write must judge flags that were latched earlier while their enables were off.

The bench reaches the first case by driving the read strobe and an alarm pulse in one cycle. It then checks both the returned old value and the flag that survives. For the second case, it latches flags with their enables clear and only afterwards writes B. Some of those writes enable a pending flag, and some only enable a flag that is not pending. Each time the bench checks that `irq` rises or falls on the write edge itself.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;

    // Indices of the control registers; software decodes these
    localparam logic [IDX_W-1:0] IDX_CTL_A = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTL_B = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_FLAGS = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_STAT  = 7'h0D;

    // Power-on contents
    localparam logic [DATA_W-1:0] A_INIT = 8'h26;
    localparam logic [DATA_W-1:0] B_INIT = 8'h02;
    localparam logic [DATA_W-1:0] D_INIT = 8'h80;

    // Bit positions shared by flags (C) and enables (B)
    localparam int BIT_SET  = 7;
    localparam int BIT_IRQF = 7;
    localparam int BIT_UIE  = 4;
    localparam int EV_LO    = 4;   // lowest event bit
    localparam int EV_N     = 3;   // PF, AF, UF
    localparam int EV_HI    = EV_LO + EV_N - 1;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_IDX_RD,
        ACC_DAT_WR,
        ACC_DAT_RD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  data;
    } bus_acc_t;

    typedef enum logic [2:0] {
        SEL_RAM,
        SEL_A,
        SEL_B,
        SEL_C,
        SEL_D
    } reg_sel_e;

    function automatic reg_sel_e sel_of(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_CTL_A: sel_of = SEL_A;
            IDX_CTL_B: sel_of = SEL_B;
            IDX_FLAGS: sel_of = SEL_C;
            IDX_STAT:  sel_of = SEL_D;
            default:   sel_of = SEL_RAM;
        endcase
    endfunction

    // Register B value as stored: SET forces the update enable low
    function automatic logic [DATA_W-1:0] b_store(input logic [DATA_W-1:0] d);
        b_store = d;
        if (d[BIT_SET]) b_store[BIT_UIE] = 1'b0;
    endfunction

endpackage

// File: rtl/rtcif_port_dec.sv
module rtcif_port_dec
    import rtcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr0,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_acc_t          acc
);

    logic [IDX_W-1:0] idx_q;

    always_comb begin
        acc.kind = ACC_NONE;
        acc.idx  = idx_q;
        acc.data = bus_wdata;
        if (bus_wr) begin
            acc.kind = bus_addr0 ? ACC_DAT_WR : ACC_IDX_WR;
        end else if (bus_rd) begin
            acc.kind = bus_addr0 ? ACC_DAT_RD : ACC_IDX_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (acc.kind == ACC_IDX_WR) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    // R1: the index port keeps only the low seven data bits
    a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr0) |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

endmodule

// File: rtl/rtcif_ram.sv
module rtcif_ram #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/rtcif_ctl_regs.sv
module rtcif_ctl_regs
    import rtcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              rd_c,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [EV_N-1:0]   ev,        // {periodic, alarm, update}
    input  logic              tk_busy,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output logic [DATA_W-1:0] reg_d,
    output logic              irq
);

    logic [DATA_W-2:0] a_low;
    logic              uip_q;
    logic [DATA_W-1:0] b_reg;
    logic [EV_N-1:0]   flags;
    logic              irqf;

    logic [DATA_W-1:0] b_next;
    logic [EV_N-1:0]   flags_base, flags_new, flags_next;
    logic              irqf_base, irqf_next;

    always_comb begin
        b_next     = wr_b ? b_store(wr_data) : b_reg;
        // A read clears first; same-cycle events land on the cleared value
        flags_base = rd_c ? '0 : flags;
        irqf_base  = rd_c ? 1'b0 : irqf;
        if (wr_b) begin
            irqf_base = |(flags & b_next[EV_HI:EV_LO]);
        end
        flags_new  = ev & ~flags_base;
        flags_next = flags_base | ev;
        irqf_next  = irqf_base | (|(flags_new & b_next[EV_HI:EV_LO]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_low <= A_INIT[DATA_W-2:0];
            uip_q <= 1'b0;
            b_reg <= B_INIT;
            flags <= '0;
            irqf  <= 1'b0;
        end else begin
            if (wr_a) a_low <= wr_data[DATA_W-2:0];
            uip_q <= tk_busy & ~b_next[BIT_SET];
            b_reg <= b_next;
            flags <= flags_next;
            irqf  <= irqf_next;
        end
    end

    always_comb begin
        reg_a = {uip_q, a_low};
        reg_b = b_reg;
        reg_c = '0;
        reg_c[BIT_IRQF]     = irqf;
        reg_c[EV_HI:EV_LO]  = flags;
        reg_d = D_INIT;
    end

    assign irq = irqf;

    // R5: a flag read with no event pending leaves nothing behind
    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_c && ev == '0) |=> (flags == '0 && !irq));

    // R8: SET written means the update enable is stored clear
    a_r8_set_clears_uie: assert property (@(posedge clk) disable iff (rst)
        (wr_b && wr_data[BIT_SET]) |=> !b_reg[BIT_UIE]);

    // R4: low bits of A take the written data
    a_r4_a_low_written: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (a_low == $past(wr_data[DATA_W-2:0])));

    // R6: an enabled event always ends with the line raised
    a_r6_irq_on_enabled: assert property (@(posedge clk) disable iff (rst)
        ((|(ev & b_reg[EV_HI:EV_LO])) && !wr_b) |=> irq);

    // R4: busy bit never shows while SET is held
    a_r4_uip_in_set: assert property (@(posedge clk) disable iff (rst)
        b_reg[BIT_SET] |-> !uip_q || $past(!b_reg[BIT_SET]));

endmodule

// File: rtl/rtcif_regfile.sv
module rtcif_regfile
    import rtcif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_addr0,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        tk_update,
    input  logic        tk_alarm,
    input  logic        tk_periodic,
    input  logic        tk_busy,
    output logic [7:0]  rd_data,
    output logic        irq,
    output logic [3:0]  ctl_rate,
    output logic [2:0]  ctl_divsel,
    output logic        ctl_set,
    output logic        ctl_sqw_en,
    output logic        ctl_binary,
    output logic        ctl_24h,
    output logic        ctl_dst
);

    bus_acc_t          acc;
    reg_sel_e          sel;
    logic              wr_a, wr_b, wr_c, rd_c, ram_we;
    logic [DATA_W-1:0] ram_q, reg_a, reg_b, reg_c, reg_d, rd_next;
    logic [EV_N-1:0]   ev;

    rtcif_port_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .bus_addr0 (bus_addr0),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .acc       (acc)
    );

    assign sel    = sel_of(acc.idx);
    assign wr_a   = (acc.kind == ACC_DAT_WR) && (sel == SEL_A);
    assign wr_b   = (acc.kind == ACC_DAT_WR) && (sel == SEL_B);
    assign wr_c   = (acc.kind == ACC_DAT_WR) && (sel == SEL_C);
    assign rd_c   = (acc.kind == ACC_DAT_RD) && (sel == SEL_C);
    assign ram_we = (acc.kind == ACC_DAT_WR) && (sel == SEL_RAM);
    assign ev     = {tk_periodic, tk_alarm, tk_update};

    rtcif_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (acc.idx),
        .wdata (acc.data),
        .rdata (ram_q)
    );

    rtcif_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .rd_c    (rd_c),
        .wr_data (acc.data),
        .ev      (ev),
        .tk_busy (tk_busy),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .reg_c   (reg_c),
        .reg_d   (reg_d),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_A:   rd_next = reg_a;
            SEL_B:   rd_next = reg_b;
            SEL_C:   rd_next = reg_c;
            SEL_D:   rd_next = reg_d;
            default: rd_next = ram_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (acc.kind == ACC_IDX_RD) begin
            rd_data <= '1;
        end else if (acc.kind == ACC_DAT_RD) begin
            rd_data <= rd_next;
        end
    end

    assign ctl_rate   = reg_a[3:0];
    assign ctl_divsel = reg_a[6:4];
    assign ctl_set    = reg_b[7];
    assign ctl_sqw_en = reg_b[3];
    assign ctl_binary = reg_b[2];
    assign ctl_24h    = reg_b[1];
    assign ctl_dst    = reg_b[0];

    // R3: a write aimed at the flag register leaves it untouched
    a_r3_flags_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_c && ev == '0) |=> $stable(reg_c));

    // R1: even-port reads return all ones
    a_r1_index_read_ones: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_rd && !bus_addr0) |=> (rd_data == 8'hFF));

endmodule

// File: tb/rtcif_regfile_tb_top.sv
`timescale 1ns/1ps
module rtcif_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr0 = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       tk_update = 1'b0;
    logic       tk_alarm = 1'b0;
    logic       tk_periodic = 1'b0;
    logic       tk_busy = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic [3:0] ctl_rate;
    logic [2:0] ctl_divsel;
    logic       ctl_set, ctl_sqw_en, ctl_binary, ctl_24h, ctl_dst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    rtcif_regfile dut_i (
        .clk (clk), .rst (rst), .bus_addr0 (bus_addr0), .bus_wdata (bus_wdata),
        .bus_rd (bus_rd), .bus_wr (bus_wr), .tk_update (tk_update),
        .tk_alarm (tk_alarm), .tk_periodic (tk_periodic), .tk_busy (tk_busy),
        .rd_data (rd_data), .irq (irq), .ctl_rate (ctl_rate),
        .ctl_divsel (ctl_divsel), .ctl_set (ctl_set), .ctl_sqw_en (ctl_sqw_en),
        .ctl_binary (ctl_binary), .ctl_24h (ctl_24h), .ctl_dst (ctl_dst)
    );

    // {is_read, port, data, expected, requirement}
    localparam int NV = 21;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h10, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h5A, 8'h00, 4'd2},
        {1'b0, 1'b0, 8'h91, 8'h00, 4'd1},
        {1'b0, 1'b1, 8'hC3, 8'h00, 4'd1},
        {1'b0, 1'b0, 8'h10, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h5A, 4'd2},
        {1'b0, 1'b0, 8'h11, 8'h00, 4'd1},
        {1'b1, 1'b1, 8'h00, 8'hC3, 4'd1},
        {1'b1, 1'b0, 8'h00, 8'hFF, 4'd1},
        {1'b0, 1'b0, 8'h8A, 8'h00, 4'd4},
        {1'b0, 1'b1, 8'hA5, 8'h00, 4'd4},
        {1'b1, 1'b1, 8'h00, 8'h25, 4'd4},
        {1'b0, 1'b0, 8'h0D, 8'h00, 4'd3},
        {1'b0, 1'b1, 8'h00, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h80, 4'd3},
        {1'b0, 1'b0, 8'h0C, 8'h00, 4'd3},
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd3},
        {1'b0, 1'b0, 8'h7F, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h3C, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h3C, 4'd2}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_addr0 = port; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic port, output logic [7:0] d);
        @(negedge clk);
        bus_addr0 = port; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(1'b0, idx);
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bus_write(1'b0, idx);
        bus_read(1'b1, d);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tk_update   = (which == 0);
        tk_alarm    = (which == 1);
        tk_periodic = (which == 2);
        @(negedge clk);
        tk_update = 1'b0; tk_alarm = 1'b0; tk_periodic = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x00 expected=0x01");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: power-on state
        check("R9 irq", {7'd0, irq}, 8'h00);
        reg_read(8'h0A, got); check("R9 A", got, 8'h26);
        reg_read(8'h0B, got); check("R9 B", got, 8'h02);
        reg_read(8'h0C, got); check("R9 C", got, 8'h00);
        reg_read(8'h0D, got); check("R9 D", got, 8'h80);

        // Vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) begin
                bus_read(VEC[i][20], got);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), got, VEC[i][11:4]);
            end else begin
                bus_write(VEC[i][20], VEC[i][19:12]);
            end
        end

        // R4: busy bit is live and cannot be written
        tk_busy = 1'b1;
        reg_read(8'h0A, got); check("R4 busy shown", got, 8'hA5);
        bus_write(1'b1, 8'h00);
        bus_read(1'b1, got); check("R4 write keeps busy", got, 8'h80);
        tk_busy = 1'b0;
        @(negedge clk);
        bus_read(1'b1, got); check("R4 busy gone", got, 8'h00);

        // R6: enabled update event
        reg_write(8'h0B, 8'h10);
        pulse(0);
        check("R6 irq raised", {7'd0, irq}, 8'h01);
        // R5: read clears
        reg_read(8'h0C, got); check("R5 flags value", got, 8'h90);
        check("R5 irq lowered", {7'd0, irq}, 8'h00);
        bus_read(1'b1, got); check("R5 cleared", got, 8'h00);
        // R6: disabled alarm is latched without irq
        reg_write(8'h0B, 8'h00);
        pulse(1);
        check("R6 no irq disabled", {7'd0, irq}, 8'h00);
        reg_read(8'h0C, got); check("R6 latched", got, 8'h20);

        // R7: enabling a pending flag raises at once
        pulse(2);
        check("R7 pending quiet", {7'd0, irq}, 8'h00);
        reg_write(8'h0B, 8'h40);
        check("R7 raise on enable", {7'd0, irq}, 8'h01);
        reg_read(8'h0C, got); check("R7 flags", got, 8'hC0);
        pulse(2);
        check("R7 periodic irq", {7'd0, irq}, 8'h01);
        reg_write(8'h0B, 8'h10);
        check("R7 lowered", {7'd0, irq}, 8'h00);
        reg_read(8'h0C, got); check("R7 irqf cleared", got, 8'h40);

        // R8: SET forces UIE clear, busy bit hidden
        reg_write(8'h0B, 8'h90);
        reg_read(8'h0B, got); check("R8 uie cleared", got, 8'h80);
        check("R11 set out", {7'd0, ctl_set}, 8'h01);
        tk_busy = 1'b1;
        @(negedge clk);
        reg_read(8'h0A, got); check("R4 busy hidden in set", got, 8'h00);
        tk_busy = 1'b0;
        reg_write(8'h0B, 8'h02);

        // R10: event collides with flag read
        reg_write(8'h0B, 8'h20);
        bus_write(1'b0, 8'h0C);
        @(negedge clk);
        bus_addr0 = 1'b1; bus_rd = 1'b1; tk_alarm = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; tk_alarm = 1'b0;
        check("R10 old value", rd_data, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h01);
        bus_read(1'b1, got); check("R10 kept", got, 8'hA0);

        // R11: control outputs
        reg_write(8'h0A, 8'h2F);
        reg_write(8'h0B, 8'h0E);
        check("R11 rate", {4'd0, ctl_rate}, 8'h0F);
        check("R11 divsel", {5'd0, ctl_divsel}, 8'h02);
        check("R11 modes", {3'd0, ctl_set, ctl_sqw_en, ctl_binary, ctl_24h, ctl_dst}, 8'h0E);

        // R9: reset mid-run
        reg_write(8'h0B, 8'h70);
        pulse(0);
        check("R9 pre irq", {7'd0, irq}, 8'h01);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        reg_read(8'h0B, got); check("R9 B after reset", got, 8'h02);
        reg_read(8'h0C, got); check("R9 C after reset", got, 8'h00);
        reg_read(8'h0A, got); check("R9 A after reset", got, 8'h26);

        finish_run();
    end

endmodule